// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit sits beside the decode stage of a five-stage in-order pipeline and owns the fetch program counter. Each cycle it looks at the control-flow kind of the instruction in decode. It compares that instruction's two source operands with a bitwise XOR followed by a zero test. It then works out the branch or jump target and loads either that target or the sequential address into the fetch PC on the next clock edge. A taken branch therefore costs at most one fetch slot. It never costs the two slots that a resolve-in-execute design would lose.

A parameter selects how that one slot is treated. With `DELAY_SLOT = 1`, the instruction that follows a branch or jump always executes, and no squash is raised. With `DELAY_SLOT = 0`, fetch is assumed to fall through (predict not taken). When a branch is taken, the unit raises a squash flag for the instruction that was fetched behind it. That squashed instruction is turned into a bubble and cannot itself redirect. For jump-and-link, the unit also provides the value to write to the link register.

An external stall freezes the unit. The PC and the squash flag keep their values, and no redirect is reported, until the stall is released. The operands are assumed to be already forwarded and correct.

Top module: `bru_decode_resolve`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `pc_o` equals the parameter `RESET_PC` and `flush_o` is 0.
- R2: When the decode instruction does not redirect and there is no stall, `pc_o` increases by 4 on the next clock edge and `taken_o` is 0.
- R3: The kind code on `id_op_i` is decoded as 0 = none, 1 = branch-if-equal, 2 = branch-if-not-equal, 3 = jump, 4 = jump-and-link; codes 5 to 7 act as none. Branch-if-equal is taken exactly when all bits of `id_rs_i` and `id_rt_i` match, and branch-if-not-equal is taken when they do not.
- R4: The target of a taken conditional branch is `id_pc_i + 4` plus the sign-extended 16-bit `id_off_i` shifted left by two, with two's-complement wrap.
- R5: Jump and jump-and-link are always taken. Their target is the top four bits of `id_pc_i + 4`, then the 26-bit `id_jidx_i`, then two zero bits.
- R6: `link_o` equals `id_pc_i + 8` when `DELAY_SLOT = 1` and `id_pc_i + 4` when `DELAY_SLOT = 0`.
- R7: With `DELAY_SLOT = 0`, a redirect taken without stall makes `flush_o` 1 on the next cycle. With `DELAY_SLOT = 1`, `flush_o` stays 0.
- R8: While `flush_o` is 1, the decode instruction is ignored: `taken_o` is 0 and `pc_o` advances by 4.
- R9: While `stall_i` is 1, `taken_o` is 0, and `pc_o` and `flush_o` keep their values on the next edge.
- R10: A redirect taken in decode appears on `pc_o` on the very next clock edge, so the fetch stream loses at most one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Pipeline stall; freezes PC and squash flag |
| id_op_i | input | 3 | Control-flow kind of the decode instruction |
| id_pc_i | input | XLEN | Address of the decode instruction |
| id_rs_i | input | XLEN | First compare operand |
| id_rt_i | input | XLEN | Second compare operand |
| id_off_i | input | 16 | Branch word offset |
| id_jidx_i | input | 26 | Jump word index |
| pc_o | output | XLEN | Fetch PC |
| flush_o | output | 1 | Squash the instruction now in decode |
| taken_o | output | 1 | Decode instruction redirects this cycle |
| link_o | output | XLEN | Return address for jump-and-link |

## Verification
Two instances, one per slot policy, receive the same stimulus. Every clock, their PC, squash flag, taken flag and link value are compared with a behavioural model of each policy.

Directed patterns cover the following cases:
- Equal operands and operands that differ only in the top bit, which tell a full-width compare from a truncated one.
- The branch-if-not-equal kind with both outcomes.
- A negative offset, which checks sign extension.
- A jump from a high address, which checks that the upper PC bits are kept.
- An unused kind code with equal operands.
- Back-to-back taken branches, where the two policies must diverge.
- Stalls placed on a branch and on a pending squash.

A long run of random kinds, operands and stalls then covers the orderings that the directed cases do not reach.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_BEQ  = 3'd1,
        K_BNE  = 3'd2,
        K_JMP  = 3'd3,
        K_JAL  = 3'd4
    } bru_kind_e;
endpackage

// File: rtl/bru_compare.sv
module bru_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = a_i[i] ^ b_i[i];
    end

    assign eq_o = ~|diff;
endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]   br_tgt_o,
    output logic [XLEN-1:0]   j_tgt_o
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int TOP_W = XLEN - JIDX_W - 2;

    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] disp;

    assign pc4      = pc_i + XLEN'(4);
    assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
    assign br_tgt_o = pc4 + disp;
    assign j_tgt_o  = {pc4[XLEN-1 -: TOP_W], jidx_i, 2'b00};
endmodule

// File: rtl/bru_decode_resolve.sv
module bru_decode_resolve #(
    parameter int              XLEN       = 32,
    parameter int              OFF_W      = 16,
    parameter int              JIDX_W     = 26,
    parameter bit              DELAY_SLOT = 1'b1,
    parameter logic [XLEN-1:0] RESET_PC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic [2:0]        id_op_i,
    input  logic [XLEN-1:0]   id_pc_i,
    input  logic [XLEN-1:0]   id_rs_i,
    input  logic [XLEN-1:0]   id_rt_i,
    input  logic [OFF_W-1:0]  id_off_i,
    input  logic [JIDX_W-1:0] id_jidx_i,
    output logic [XLEN-1:0]   pc_o,
    output logic              flush_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   link_o
);
    import bru_pkg::*;

    localparam int LINK_OFS = DELAY_SLOT ? 8 : 4;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            flush;
    } bru_state_t;

    bru_state_t state_d, state_q;

    logic            ops_eq;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;
    logic            cond;
    logic            is_jump;
    logic            take;
    bru_kind_e       kind;

    bru_compare #(.W(XLEN)) u_cmp (
        .a_i  (id_rs_i),
        .b_i  (id_rt_i),
        .eq_o (ops_eq)
    );

    bru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
        .pc_i     (id_pc_i),
        .off_i    (id_off_i),
        .jidx_i   (id_jidx_i),
        .br_tgt_o (br_tgt),
        .j_tgt_o  (j_tgt)
    );

    always_comb begin
        kind    = bru_kind_e'(id_op_i);
        cond    = 1'b0;
        is_jump = 1'b0;
        case (kind)
            K_BEQ:   cond = ops_eq;
            K_BNE:   cond = ~ops_eq;
            K_JMP,
            K_JAL: begin
                cond    = 1'b1;
                is_jump = 1'b1;
            end
            default: cond = 1'b0;
        endcase

        // a squashed decode slot or a stalled pipe never redirects
        take    = cond & ~stall_i & ~state_q.flush;

        state_d = state_q;
        if (!stall_i) begin
            if (take) begin
                state_d.pc = is_jump ? j_tgt : br_tgt;
            end else begin
                state_d.pc = state_q.pc + XLEN'(4);
            end
            state_d.flush = take & ~DELAY_SLOT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc    <= RESET_PC;
            state_q.flush <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o    = state_q.pc;
    assign flush_o = state_q.flush;
    assign taken_o = take;
    assign link_o  = id_pc_i + XLEN'(LINK_OFS);
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int XLEN       = 32,
    parameter bit DELAY_SLOT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic [2:0]      id_op_i,
    input logic [XLEN-1:0] id_rs_i,
    input logic [XLEN-1:0] id_rt_i,
    input logic [XLEN-1:0] pc_o,
    input logic            flush_o,
    input logic            taken_o
);
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        stall_i |=> ($stable(pc_o) && $stable(flush_o)));

    p_stall_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        stall_i |-> !taken_o);

    p_squash_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        flush_o |-> !taken_o);

    p_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (!stall_i && !taken_o) |=> (pc_o == $past(pc_o) + XLEN'(4)));

    p_flush_policy_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (!stall_i && taken_o) |=> (flush_o == !DELAY_SLOT));

    p_take_kind_r3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        taken_o |-> (id_op_i inside {3'd1, 3'd2, 3'd3, 3'd4}));

    p_beq_equal_r3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (id_op_i == 3'd1 && !stall_i && !flush_o && id_rs_i == id_rt_i) |-> taken_o);
endmodule

bind bru_decode_resolve bru_checker #(.XLEN(XLEN), .DELAY_SLOT(DELAY_SLOT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .id_op_i (id_op_i),
    .id_rs_i (id_rs_i),
    .id_rt_i (id_rt_i),
    .pc_o    (pc_o),
    .flush_o (flush_o),
    .taken_o (taken_o)
);

// File: tb/tb_bru_decode_resolve.sv
module tb_bru_decode_resolve;
    localparam logic [31:0] RPC  = 32'h0000_1000;
    localparam logic [2:0]  NONE = 3'd0;
    localparam logic [2:0]  BEQ  = 3'd1;
    localparam logic [2:0]  BNE  = 3'd2;
    localparam logic [2:0]  JMP  = 3'd3;
    localparam logic [2:0]  JAL  = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [2:0]  op;
    logic [31:0] pc, rs, rt;
    logic [15:0] off;
    logic [25:0] jidx;

    logic [31:0] o_pc [2];
    logic        o_fl [2];
    logic        o_tk [2];
    logic [31:0] o_lk [2];

    logic [31:0] m_pc [2];
    logic        m_fl [2];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // index 0: delay-slot policy, index 1: squash policy
    bru_decode_resolve #(.DELAY_SLOT(1'b1), .RESET_PC(RPC)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall), .id_op_i(op), .id_pc_i(pc),
        .id_rs_i(rs), .id_rt_i(rt), .id_off_i(off), .id_jidx_i(jidx),
        .pc_o(o_pc[0]), .flush_o(o_fl[0]), .taken_o(o_tk[0]), .link_o(o_lk[0]));

    bru_decode_resolve #(.DELAY_SLOT(1'b0), .RESET_PC(RPC)) dut_fl (
        .clk(clk), .rst_n(rst_n), .stall_i(stall), .id_op_i(op), .id_pc_i(pc),
        .id_rs_i(rs), .id_rt_i(rt), .id_off_i(off), .id_jidx_i(jidx),
        .pc_o(o_pc[1]), .flush_o(o_fl[1]), .taken_o(o_tk[1]), .link_o(o_lk[1]));

    function automatic logic cond_f();
        case (op)
            BEQ:      return rs == rt;
            BNE:      return rs != rt;
            JMP, JAL: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] tgt_f();
        logic [31:0] nxt = pc + 32'd4;
        if (op == JMP || op == JAL) return {nxt[31:28], jidx, 2'b00};
        return nxt + {{14{off[15]}}, off, 2'b00};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp, input int m);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s policy%0d act=%h exp=%h", tag, what, m, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] o, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] f, input logic [25:0] j,
                       input logic s, input string tag);
        logic tk_e [2];
        logic [31:0] tg;
        op = o; pc = p; rs = a; rt = b; off = f; jidx = j; stall = s;
        #1;
        tg = tgt_f();
        for (int m = 0; m < 2; m++) begin
            tk_e[m] = !s && !m_fl[m] && cond_f();
            chk(tag, "pc", o_pc[m], m_pc[m], m);
            chk(tag, "flush", 32'(o_fl[m]), 32'(m_fl[m]), m);
            chk(tag, "taken", 32'(o_tk[m]), 32'(tk_e[m]), m);
            chk(tag, "link", o_lk[m], p + ((m == 0) ? 32'd8 : 32'd4), m);
        end
        @(posedge clk);
        for (int m = 0; m < 2; m++) begin
            if (!s) begin
                m_pc[m] = tk_e[m] ? tg : m_pc[m] + 32'd4;
                m_fl[m] = (m == 1) && tk_e[m];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 60000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stall = 1'b0; op = NONE; pc = '0; rs = '0; rt = '0;
        off = '0; jidx = '0;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk("R1", "pc in reset", o_pc[m], RPC, m);
            chk("R1", "flush in reset", 32'(o_fl[m]), 32'd0, m);
            m_pc[m] = RPC;
            m_fl[m] = 1'b0;
        end
        rst_n = 1'b1;

        cyc(NONE, 32'h0000_2000, 32'd1, 32'd2, 16'h0004, 26'd0, 1'b0, "R1");
        cyc(NONE, 32'h0000_2004, 32'd7, 32'd7, 16'h0004, 26'd0, 1'b0, "R2");
        cyc(NONE, 32'h0000_2008, 32'd7, 32'd7, 16'h0004, 26'd0, 1'b0, "R2");
        // taken equal branch, then a second taken branch in the next slot
        cyc(BEQ, 32'h0000_2000, 32'd5, 32'd5, 16'h0010, 26'd0, 1'b0, "R10");
        cyc(BEQ, 32'h0000_2044, 32'd9, 32'd9, 16'h0020, 26'd0, 1'b0, "R8");
        cyc(NONE, 32'h0000_2048, 32'd0, 32'd0, 16'h0000, 26'd0, 1'b0, "R7");
        // operands differ only in the top bit
        cyc(BEQ, 32'h0000_3000, 32'h8000_0000, 32'h0, 16'h0010, 26'd0, 1'b0, "R3");
        cyc(BNE, 32'h0000_3004, 32'h0000_0001, 32'h0, 16'h0008, 26'd0, 1'b0, "R3");
        cyc(NONE, 32'h0000_3008, 32'd0, 32'd0, 16'h0000, 26'd0, 1'b0, "R3");
        cyc(BNE, 32'h0000_300C, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0008, 26'd0, 1'b0, "R3");
        // negative offset
        cyc(BEQ, 32'h0000_4000, 32'd3, 32'd3, 16'hFFF0, 26'd0, 1'b0, "R4");
        cyc(NONE, 32'h0000_4004, 32'd0, 32'd1, 16'h0000, 26'd0, 1'b0, "R4");
        // jumps from a high address
        cyc(JMP, 32'hA000_0000, 32'd0, 32'd1, 16'h0000, 26'h123_4567, 1'b0, "R5");
        cyc(NONE, 32'hA000_0004, 32'd0, 32'd1, 16'h0000, 26'h0, 1'b0, "R5");
        cyc(JAL, 32'hF000_0010, 32'd0, 32'd1, 16'h0000, 26'h3FF_FFFF, 1'b0, "R6");
        cyc(NONE, 32'hF000_0014, 32'd0, 32'd1, 16'h0000, 26'h0, 1'b0, "R6");
        // unused kind code
        cyc(3'd5, 32'h0000_5000, 32'd4, 32'd4, 16'h0040, 26'h1, 1'b0, "R3");
        cyc(3'd7, 32'h0000_5004, 32'd4, 32'd4, 16'h0040, 26'h1, 1'b0, "R3");
        // stall over a taken branch
        cyc(BEQ, 32'h0000_6000, 32'd8, 32'd8, 16'h0100, 26'd0, 1'b1, "R9");
        cyc(BEQ, 32'h0000_6000, 32'd8, 32'd8, 16'h0100, 26'd0, 1'b1, "R9");
        cyc(BEQ, 32'h0000_6000, 32'd8, 32'd8, 16'h0100, 26'd0, 1'b0, "R9");
        // stall while a squash is pending
        cyc(JMP, 32'h0000_7000, 32'd0, 32'd0, 16'h0000, 26'h0_0200, 1'b0, "R7");
        cyc(BEQ, 32'h0000_0800, 32'd2, 32'd2, 16'h0004, 26'd0, 1'b1, "R9");
        cyc(BEQ, 32'h0000_0800, 32'd2, 32'd2, 16'h0004, 26'd0, 1'b0, "R8");
        cyc(NONE, 32'h0000_0804, 32'd2, 32'd2, 16'h0004, 26'd0, 1'b0, "R2");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = ($urandom_range(0, 1) == 0) ? a : $urandom;
            cyc(3'($urandom_range(0, 7)), $urandom, a, b, 16'($urandom),
                26'($urandom), ($urandom_range(0, 4) == 0), "R2");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule